// File: doc/BRIEF.md
# Indexed Configuration Register Port

This unit gives a host access to a set of configuration registers through just two I/O addresses: an index port and a data port. At first the unit ignores register traffic. Two consecutive writes of an unlock key to the index port put it into configuration mode. In that mode a write to the index port chooses a register, and the data port then reads or writes that register. Writing an exit code to the index port leaves configuration mode.

Indices below 0x30 reach a global window that every device shares. Index 0x07 holds the device selector. Indices 0x30 and above reach the bank of the device that the selector names. Each bank has an activate bit and a 16-bit I/O base address. Both are driven straight out to the peripherals that use them.

A lock bit in global register 0x26 freezes the register contents. Two resets are provided. The cold reset restores every default. The warm reset only drops the access session and keeps every stored value.

Top module: `cfg_index_port`

## Requirements
- R1: After a cold reset, configuration mode is off, `dev_active` is all zero and every base in `dev_base` is 0x0000.
- R2: Configuration mode starts only after two index-port writes of 0x87 in a row. Any index-port or data-port write between them restarts the match, and a single 0x87 does not enter the mode.
- R3: In configuration mode, an index-port write of any value other than 0x AA sets the current index. A data-port read returns the register at that index. An index-port read returns the index. Outside configuration mode, both ports read 0xFF, and any read of another address also returns 0xFF.
- R4: An index-port write of 0xAA in configuration mode leaves the mode. Data-port writes made outside configuration mode change no register.
- R5: Register 0x07 holds an 8-bit device selector. Indices 0x30, 0x60 and 0x61 address the bank of the selected device. If the selector is NUM_DEV or higher, those indices read 0x00 and ignore writes.
- R6: Registers 0x20 to 0x2F are one shared set of 8-bit read/write registers. A value written there reads back the same whatever device is selected.
- R7: Bit 0 of bank register 0x30 drives `dev_active[d]`. The other bits of 0x30 read as 0.
- R8: Bank register 0x60 holds bits 15:8 and register 0x61 holds bits 7:0 of `dev_base[d*16 +: 16]`.
- R9: While bit 5 of register 0x26 is set, data-port writes are ignored for every index except 0x07 and 0x26.
- R10: A warm reset ends configuration mode, clears any partial key match and sets the current index to 0x00. It leaves registers 0x07, 0x20 to 0x2F and every bank unchanged.
- R11: A cold reset issued after registers were written brings them all back to their defaults: 0x00, with the outputs as in R1.
- R12: Indices that are not implemented (below 0x07, 0x08 to 0x1F, and bank indices other than 0x30, 0x60 and 0x61) read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset; restores all defaults |
| warm_rst_n | input | 1 | Synchronous active-low warm reset; ends the session only |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | ADDR_W | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational from the current state |
| cfg_mode | output | 1 | High while configuration mode is active |
| dev_active | output | NUM_DEV | Per-device activate bits |
| dev_base | output | NUM_DEV*16 | Per-device I/O base addresses, device d at bits d*16 +: 16 |

## Verification
The bench builds the block with NUM_DEV = 3. That makes selector value 3 the first one with no bank behind it, so the out-of-range path of R5 is exercised next to three real banks. The ports stay at their default addresses 0x2E and 0x2F. This keeps a long random run of index and data writes, with keys, exit codes and lock toggles mixed in, mostly aimed at registers that exist. A queue-free integer model follows the key match, the index, the selector and all stored bytes. It is compared against the outputs on every clock and against every read.

// File: rtl/cfg_pkg.sv
// Shared constants and types for the indexed configuration register port.
// Assumes 8-bit register indices and 8-bit register data.
package cfg_pkg;
    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_HALF = 2'd1,
        KS_CFG  = 2'd2
    } key_state_e;

    localparam logic [7:0] IDX_SEL     = 8'h07;
    localparam logic [3:0] GLB_HI_NIB  = 4'h2;
    localparam logic [7:0] IDX_LOCKREG = 8'h26;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam int         GLB_CNT     = 16;
    localparam logic [7:0] READ_IDLE   = 8'hFF;
endpackage

// File: rtl/cfg_key_fsm.sv
// Key matcher and session state. Two consecutive index-port writes of
// KEY_BYTE enter configuration mode. Any other port write restarts the
// match. EXIT_BYTE on the index port leaves the mode.
// Assumes single-cycle write strobes that are already decoded per port.
module cfg_key_fsm #(
    parameter logic [7:0] KEY_BYTE  = 8'h87,
    parameter logic [7:0] EXIT_BYTE = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic       cfg_mode,
    output logic       idx_load
);
    import cfg_pkg::*;

    key_state_e st_q;

    // Advance the key match and session state on each port write.
    always_ff @(posedge clk) begin
        if (!rst_n || !warm_rst_n) begin
            st_q <= KS_IDLE;
        end else begin
            case (st_q)
                KS_IDLE: if (idx_wr && wdata == KEY_BYTE) st_q <= KS_HALF;
                KS_HALF: begin
                    if (idx_wr && wdata == KEY_BYTE) st_q <= KS_CFG;
                    else if (idx_wr || dat_wr)       st_q <= KS_IDLE;
                end
                KS_CFG:  if (idx_wr && wdata == EXIT_BYTE) st_q <= KS_IDLE;
                default: st_q <= KS_IDLE;
            endcase
        end
    end

    // Mode flag and index-load strobe for the register file.
    always_comb begin
        cfg_mode = (st_q == KS_CFG);
        idx_load = cfg_mode && idx_wr && (wdata != EXIT_BYTE);
    end
endmodule

// File: rtl/cfg_global_regs.sv
// Current index, device selector and the shared global window 0x20..0x2F.
// The lock bit lives in global register 0x26. Index and selector writes
// come only from the session logic. Warm reset clears only the index.
module cfg_global_regs #(
    parameter int LOCK_BIT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_rst_n,
    input  logic       idx_load,
    input  logic       reg_wr,
    input  logic [7:0] wdata,
    output logic [7:0] cur_index,
    output logic [7:0] dev_sel,
    output logic       lock_on,
    output logic       glb_hit,
    output logic [7:0] glb_rdata
);
    import cfg_pkg::*;

    logic [7:0] glb_q [GLB_CNT];
    logic       in_window;
    logic       glb_wr_ok;

    // Window decode and write permission for the global registers.
    always_comb begin
        in_window = (cur_index[7:4] == GLB_HI_NIB);
        glb_wr_ok = reg_wr && in_window && (!lock_on || cur_index == IDX_LOCKREG);
        glb_hit   = in_window;
        glb_rdata = glb_q[cur_index[3:0]];
        lock_on   = glb_q[IDX_LOCKREG[3:0]][LOCK_BIT];
    end

    // Current index: cleared by either reset, loaded by index-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !warm_rst_n) cur_index <= 8'h00;
        else if (idx_load)         cur_index <= wdata;
    end

    // Device selector: cold reset only, and exempt from the lock.
    always_ff @(posedge clk) begin
        if (!rst_n)                               dev_sel <= 8'h00;
        else if (reg_wr && cur_index == IDX_SEL)  dev_sel <= wdata;
    end

    generate
        for (genvar g = 0; g < GLB_CNT; g++) begin : g_glb
            // One shared global byte, cold reset only.
            always_ff @(posedge clk) begin
                if (!rst_n)                                      glb_q[g] <= 8'h00;
                else if (glb_wr_ok && cur_index[3:0] == 4'(g))   glb_q[g] <= wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/cfg_dev_bank.sv
// Register bank for one logical device: activate bit (0x30) and 16-bit
// base (0x60 high, 0x61 low). Holds its contents across a warm reset.
// Assumes the parent gates writes with configuration mode.
module cfg_dev_bank #(
    parameter int DEV_ID = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        lock_on,
    input  logic [7:0]  dev_sel,
    input  logic [7:0]  cur_index,
    input  logic [7:0]  wdata,
    output logic        active,
    output logic [15:0] base,
    output logic [7:0]  rdata
);
    import cfg_pkg::*;

    localparam logic [7:0] MY_ID = 8'(DEV_ID);

    logic chosen;
    logic wr_ok;

    // Selection, write permission and read-back for this bank.
    always_comb begin
        chosen = (dev_sel == MY_ID);
        wr_ok  = reg_wr && chosen && !lock_on;
        rdata  = 8'h00;
        if (chosen) begin
            case (cur_index)
                IDX_ACT:     rdata = {7'd0, active};
                IDX_BASE_HI: rdata = base[15:8];
                IDX_BASE_LO: rdata = base[7:0];
                default:     rdata = 8'h00;
            endcase
        end
    end

    // Activate bit and base halves, cold reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= 16'h0000;
        end else if (wr_ok) begin
            if (cur_index == IDX_ACT)     active     <= wdata[0];
            if (cur_index == IDX_BASE_HI) base[15:8] <= wdata;
            if (cur_index == IDX_BASE_LO) base[7:0]  <= wdata;
        end
    end
endmodule

// File: rtl/cfg_index_port.sv
// Top level of the indexed configuration register port. Decodes the two
// host ports, runs the key matcher, holds the global registers and one
// bank per device, and muxes read data. Reads are combinational.
// Assumes the host does not assert io_rd and io_wr in the same cycle.
module cfg_index_port #(
    parameter int                ADDR_W    = 16,
    parameter int                NUM_DEV   = 4,
    parameter logic [ADDR_W-1:0] IDX_ADDR  = 16'h002E,
    parameter logic [ADDR_W-1:0] DAT_ADDR  = 16'h002F,
    parameter logic [7:0]        KEY_BYTE  = 8'h87,
    parameter logic [7:0]        EXIT_BYTE = 8'hAA,
    parameter int                LOCK_BIT  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  warm_rst_n,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic                  cfg_mode,
    output logic [NUM_DEV-1:0]    dev_active,
    output logic [NUM_DEV*16-1:0] dev_base
);
    import cfg_pkg::*;

    localparam logic [7:0] BANK_LO = IDX_ACT;

    logic       idx_wr, dat_wr, idx_load, reg_wr;
    logic [7:0] cur_index, dev_sel, glb_rdata, bank_rdata;
    logic       lock_on, glb_hit;
    logic [7:0] bank_rd [NUM_DEV];

    // Port decode for host writes.
    always_comb begin
        idx_wr = io_wr && (io_addr == IDX_ADDR);
        dat_wr = io_wr && (io_addr == DAT_ADDR);
        reg_wr = dat_wr && cfg_mode;
    end

    cfg_key_fsm #(.KEY_BYTE(KEY_BYTE), .EXIT_BYTE(EXIT_BYTE)) u_key (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
        .idx_wr(idx_wr), .dat_wr(dat_wr), .wdata(io_wdata),
        .cfg_mode(cfg_mode), .idx_load(idx_load)
    );

    cfg_global_regs #(.LOCK_BIT(LOCK_BIT)) u_glb (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
        .idx_load(idx_load), .reg_wr(reg_wr), .wdata(io_wdata),
        .cur_index(cur_index), .dev_sel(dev_sel), .lock_on(lock_on),
        .glb_hit(glb_hit), .glb_rdata(glb_rdata)
    );

    generate
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
            cfg_dev_bank #(.DEV_ID(d)) u_bank (
                .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .lock_on(lock_on),
                .dev_sel(dev_sel), .cur_index(cur_index), .wdata(io_wdata),
                .active(dev_active[d]), .base(dev_base[d*16 +: 16]),
                .rdata(bank_rd[d])
            );
        end
    endgenerate

    // Merge bank read data; only the selected bank returns nonzero.
    always_comb begin
        bank_rdata = 8'h00;
        for (int d = 0; d < NUM_DEV; d++) bank_rdata = bank_rdata | bank_rd[d];
    end

    // Host read mux across ports and register windows.
    always_comb begin
        io_rdata = READ_IDLE;
        if (io_rd && cfg_mode) begin
            if (io_addr == IDX_ADDR) begin
                io_rdata = cur_index;
            end else if (io_addr == DAT_ADDR) begin
                if (cur_index == IDX_SEL)      io_rdata = dev_sel;
                else if (glb_hit)              io_rdata = glb_rdata;
                else if (cur_index >= BANK_LO) io_rdata = bank_rdata;
                else                           io_rdata = 8'h00;
            end
        end
    end
endmodule

// File: rtl/cfg_index_port_chk.sv
// Assertion checker for cfg_index_port, attached with bind. Watches the
// host ports, the outputs, the lock state and the current index.
module cfg_index_port_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                NUM_DEV   = 4,
    parameter logic [ADDR_W-1:0] IDX_ADDR  = 16'h002E,
    parameter logic [ADDR_W-1:0] DAT_ADDR  = 16'h002F,
    parameter logic [7:0]        KEY_BYTE  = 8'h87,
    parameter logic [7:0]        EXIT_BYTE = 8'hAA
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  warm_rst_n,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic [ADDR_W-1:0]     io_addr,
    input logic [7:0]            io_wdata,
    input logic [7:0]            io_rdata,
    input logic                  cfg_mode,
    input logic [NUM_DEV-1:0]    dev_active,
    input logic [NUM_DEV*16-1:0] dev_base,
    input logic                  lock_on,
    input logic [7:0]            cur_index
);
    // R2: the mode can only begin right after a key write on the index port.
    a_r2_entry_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> $past(io_wr && io_addr == IDX_ADDR && io_wdata == KEY_BYTE));

    // R4: the exit code ends the session on the next cycle.
    a_r4_exit_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_wr && io_addr == IDX_ADDR && io_wdata == EXIT_BYTE) |=> !cfg_mode);

    // R4: outside the session no bank output moves.
    a_r4_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> ($stable(dev_active) && $stable(dev_base)));

    // R3: reads outside the session return all ones.
    a_r3_idle_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_rd) |-> io_rdata == 8'hFF);

    // R9: locked data writes leave the banks untouched.
    a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_on && io_wr && io_addr == DAT_ADDR && cur_index != 8'h26 && cur_index != 8'h07)
        |=> ($stable(dev_active) && $stable(dev_base)));

    // R10: warm reset always ends the session.
    a_r10_warm_drops_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst_n |=> !cfg_mode);
endmodule

bind cfg_index_port cfg_index_port_chk #(
    .ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .IDX_ADDR(IDX_ADDR),
    .DAT_ADDR(DAT_ADDR), .KEY_BYTE(KEY_BYTE), .EXIT_BYTE(EXIT_BYTE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n), .io_wr(io_wr),
    .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_mode(cfg_mode), .dev_active(dev_active), .dev_base(dev_base),
    .lock_on(lock_on), .cur_index(cur_index)
);

// File: tb/cfg_index_port_bench.sv
// Self-checking bench with a behavioural model of the register port.
module cfg_index_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, warm_rst_n = 1'b1;
    logic          io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0]   io_addr = 16'h0;
    logic [7:0]    io_wdata = 8'h0;
    logic [7:0]    io_rdata;
    logic          cfg_mode;
    logic [ND-1:0] dev_active;
    logic [ND*16-1:0] dev_base;

    cfg_index_port #(.NUM_DEV(ND)) u_cfg_index_port (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n), .io_wr(io_wr),
        .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_mode(cfg_mode), .dev_active(dev_active), .dev_base(dev_base)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0;
    bit run = 0, done = 0;

    // Model state: session 0 idle, 1 one key seen, 2 configuration mode.
    int m_st, m_idx, m_sel;
    int m_glb [16];
    int m_act [ND];
    int m_base [ND];

    function automatic void m_cold();
        m_st = 0; m_idx = 0; m_sel = 0;
        foreach (m_glb[i]) m_glb[i] = 0;
        for (int d = 0; d < ND; d++) begin m_act[d] = 0; m_base[d] = 0; end
    endfunction

    function automatic bit m_locked();
        return m_glb[6][5];
    endfunction

    function automatic void m_write(int a, int v);
        if (a == 'h2E) begin
            if (m_st == 2) begin
                if (v == 'hAA) m_st = 0; else m_idx = v;
            end else m_st = (v == 'h87) ? m_st + 1 : 0;
        end else if (a == 'h2F) begin
            if (m_st != 2) m_st = 0;
            else if (m_idx == 'h07) m_sel = v;
            else if (m_idx >= 'h20 && m_idx <= 'h2F) begin
                if (!m_locked() || m_idx == 'h26) m_glb[m_idx - 'h20] = v;
            end else if (m_sel < ND && !m_locked()) begin
                if (m_idx == 'h30) m_act[m_sel] = v & 1;
                if (m_idx == 'h60) m_base[m_sel] = (m_base[m_sel] & 'hFF) | (v << 8);
                if (m_idx == 'h61) m_base[m_sel] = (m_base[m_sel] & 'hFF00) | v;
            end
        end
    endfunction

    function automatic int m_read(int a);
        if (m_st != 2) return 'hFF;
        if (a == 'h2E) return m_idx;
        if (a != 'h2F) return 'hFF;
        if (m_idx == 'h07) return m_sel;
        if (m_idx >= 'h20 && m_idx <= 'h2F) return m_glb[m_idx - 'h20];
        if (m_sel >= ND) return 0;
        if (m_idx == 'h30) return m_act[m_sel];
        if (m_idx == 'h60) return m_base[m_sel] >> 8;
        if (m_idx == 'h61) return m_base[m_sel] & 'hFF;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs with the model on every clock (R1, R2, R7, R8).
    always @(negedge clk) if (run) begin
        check("R2 mode", int'(cfg_mode), int'(m_st == 2));
        for (int d = 0; d < ND; d++) begin
            check("R7 active", int'(dev_active[d]), m_act[d]);
            check("R8 base", int'(dev_base[d*16 +: 16]), m_base[d]);
        end
    end

    task automatic wr(int a, int v);
        io_addr = 16'(a); io_wdata = 8'(v); io_wr = 1'b1;
        @(posedge clk);
        m_write(a, v);
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        io_addr = 16'(a); io_rd = 1'b1;
        #1;
        check(tag, int'(io_rdata), m_read(a));
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic rd_exp(int a, int exp, string tag);
        io_addr = 16'(a); io_rd = 1'b1;
        #1;
        check(tag, int'(io_rdata), exp);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic cold();
        rst_n = 1'b0;
        @(posedge clk);
        m_cold();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic warm();
        warm_rst_n = 1'b0;
        @(posedge clk);
        m_st = 0; m_idx = 0;
        @(negedge clk);
        warm_rst_n = 1'b1;
    endtask

    task automatic sel_wr(int idx, int v);
        wr('h2E, idx); wr('h2F, v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        finish_run();
    end

    initial begin
        m_cold();
        @(negedge clk); @(negedge clk);
        cold();
        run = 1;
        // R1: reset state; R3 reads return 0xFF when idle.
        rd_exp('h2F, 'hFF, "R1 idle data read");
        rd_exp('h2E, 'hFF, "R3 idle index read");
        check("R1 active", int'(dev_active), 0);
        // R2: interrupted key does not enter, two in a row do.
        wr('h2E, 'h87); wr('h2F, 'h00); wr('h2E, 'h87);
        check("R2 no entry after break", int'(cfg_mode), 0);
        wr('h2E, 'h87);
        check("R2 entry", int'(cfg_mode), 1);
        // R7/R8/R3: device 1 bank.
        sel_wr('h07, 1); sel_wr('h30, 'hFF);
        rd_exp('h2F, 'h01, "R7 act readback");
        sel_wr('h60, 'h12); sel_wr('h61, 'h34);
        rd_exp('h2F, 'h34, "R8 base low");
        rd_exp('h2E, 'h61, "R3 index read");
        check("R8 base out", int'(dev_base[31:16]), 'h1234);
        // R5: device 2 and out-of-range device 3.
        sel_wr('h07, 2); sel_wr('h60, 'hAB);
        sel_wr('h07, 3); sel_wr('h30, 'h01);
        rd_exp('h2F, 'h00, "R5 out of range read");
        check("R5 no bank touched", int'(dev_active), 'b010);
        // R6: shared global register.
        sel_wr('h07, 0); sel_wr('h22, 'h5A);
        sel_wr('h07, 2); wr('h2E, 'h22);
        rd_exp('h2F, 'h5A, "R6 shared global");
        // R12: unimplemented indices.
        sel_wr('h10, 'h77); rd_exp('h2F, 'h00, "R12 low hole");
        sel_wr('h40, 'h77); rd_exp('h2F, 'h00, "R12 bank hole");
        // R9: lock.
        sel_wr('h26, 'h20);
        sel_wr('h07, 0); sel_wr('h30, 'h01);
        check("R9 locked bank", int'(dev_active[0]), 0);
        sel_wr('h22, 'h11); rd_exp('h2F, 'h5A, "R9 locked global");
        wr('h2E, 'h07); rd_exp('h2F, 'h00, "R9 selector free");
        sel_wr('h26, 'h00); sel_wr('h30, 'h01);
        check("R9 unlocked", int'(dev_active[0]), 1);
        // R4: exit, then ignored data write.
        wr('h2E, 'hAA);
        check("R4 exit", int'(cfg_mode), 0);
        wr('h2E, 'h30); wr('h2F, 'h00);
        check("R4 ignored write", int'(dev_active[0]), 1);
        // R10: warm reset in mode and between keys.
        wr('h2E, 'h87); wr('h2E, 'h87); wr('h2E, 'h60);
        warm();
        check("R10 warm exit", int'(cfg_mode), 0);
        wr('h2E, 'h87); wr('h2E, 'h87);
        rd_exp('h2E, 'h00, "R10 index cleared");
        wr('h2E, 'h07); rd_exp('h2F, 'h00, "R10 selector kept");
        wr('h2E, 'h22); rd_exp('h2F, 'h5A, "R10 global kept");
        wr('h2E, 'hAA); wr('h2E, 'h87); warm(); wr('h2E, 'h87);
        check("R10 key match cleared", int'(cfg_mode), 0);
        // R3: random mix of writes and reads.
        for (int n = 0; n < 2000; n++) begin
            int pick, idx, val;
            pick = int'($urandom_range(0, 9));
            case (pick)
                0: idx = 'h07; 1: idx = 'h20; 2: idx = 'h26; 3: idx = 'h30;
                4: idx = 'h60; 5: idx = 'h61; 6: idx = 'h87; 7: idx = 'hAA;
                8: idx = 'h10; default: idx = 'h2B;
            endcase
            val = int'($urandom_range(0, 255));
            if ($urandom_range(0, 3) == 0) val = int'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 0) wr('h2E, idx);
            else wr('h2F, val);
            rd('h2F, "R3 random data read");
            rd('h2E, "R3 random index read");
        end
        // R11: cold reset restores defaults.
        wr('h2E, 'h87); wr('h2E, 'h87); sel_wr('h07, 1); sel_wr('h30, 1);
        cold();
        check("R11 active", int'(dev_active), 0);
        check("R11 base", int'(dev_base), 0);
        wr('h2E, 'h87); wr('h2E, 'h87); wr('h2E, 'h07);
        rd_exp('h2F, 'h00, "R11 selector");
        run = 0;
        finish_run();
    end
endmodule